// File: doc/BRIEF.md
# Packed Float24 Vector Loader

This block gathers a stream of 32-bit register writes into four-component vectors of 24-bit floats and writes each finished vector into an indexed vector memory. A shared index register picks the destination slot. It moves forward by one after every vector that is stored, so a driver can load a run of consecutive slots by setting the index once and then streaming words.

Two input formats are supported, and the format input is sampled with every word. In packed format, three words carry four 24-bit values whose fields straddle the word boundaries. In single-precision format, four IEEE-754 single words each carry one component, and each word is converted to the 24-bit float layout: 1 sign bit, 7 exponent bits with bias 63, and 16 mantissa bits. In both formats the first word supplies the highest component (w), so the components arrive in reverse order.

A vector whose index lies outside the memory is dropped. The block then raises an error pulse and leaves the index where it is. Writing the index register also discards any partly gathered vector.

Top module: `fvl_loader`

## Requirements
- R1: After synchronous active-low reset, `mem_we` and `range_err` are 0, the index is 0 and no words are pending.
- R2: With `fmt_f32`=0, the third accepted word completes a vector. With words a, b, c in arrival order, the components are w=a[31:8], z={a[7:0],b[31:16]}, y={b[15:0],c[31:24]} and x=c[23:0]. `mem_data` is {w,z,y,x}, with w in bits [95:72] and x in bits [23:0].
- R3: With `fmt_f32`=1, the fourth accepted word completes a vector. Word i (counting from 0) becomes component 3-i, so the first word is converted into w and the last into x.
- R4: A single word with biased exponent e in the range 65..190 converts to {sign, e-64 in 7 bits, mantissa bits [22:7]}. The mantissa is truncated, not rounded.
- R5: A single word with e ≤ 64 (this includes zero and denormals) converts to a signed zero: {sign, 23'b0}.
- R6: A single word with e ≥ 191 (this includes infinities and NaNs) saturates to a signed infinity: {sign, 7'h7F, 16'h0}.
- R7: A completed vector is presented on `mem_we`/`mem_addr`/`mem_data` in the cycle after the clock edge that takes its last word, and `mem_we` is high for exactly one cycle.
- R8: Each stored vector advances the index by one, so consecutive vectors go to consecutive addresses.
- R9: A completed vector whose index is `NUM_VEC` (96) or more is not written. `range_err` pulses for one cycle, with the same timing as R7, and the index stays unchanged.
- R10: `idx_set` loads `idx_val` into the index and clears the count of pending words.
- R11: A word presented in the same cycle as `idx_set` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_vld | input | 1 | Word write strobe |
| word_data | input | 32 | Word being written |
| fmt_f32 | input | 1 | 1 = single-precision words, 0 = packed words |
| idx_set | input | 1 | Index register write strobe |
| idx_val | input | 7 | New index value |
| mem_we | output | 1 | Vector memory write enable |
| mem_addr | output | 7 | Vector memory write address |
| mem_data | output | 96 | Vector {w,z,y,x}, 24 bits each |
| range_err | output | 1 | One-cycle pulse when a vector is dropped as out of range |

## Verification
Every result is registered once, so the write port and the error pulse appear exactly one cycle after the edge that takes the final word. The index reload and the clearing of pending words take effect at the edge that takes `idx_set`. The bench drives its inputs on falling edges and holds each strobe for one cycle. It reads the outputs at the next falling edge, which is half a cycle after the edge that registers them, and checks at the falling edge after that that the pulse has cleared. The out-of-range cases and the cases that clear pending words are judged from the address and data of the next store, which proves which words and which index survived.

// File: rtl/fvl_pkg.sv
// Package: shared widths and vector type for the float24 vector loader.
// Assumes a 32-bit word bus and four 24-bit components per vector.
package fvl_pkg;
    localparam int WORD_W = 32;
    localparam int COMP_W = 24;
    localparam int NCOMP  = 4;
    localparam int VEC_W  = COMP_W * NCOMP;

    typedef logic [COMP_W-1:0] f24_t;

    // First member is most significant: w occupies [95:72], x occupies [23:0].
    typedef struct packed {
        f24_t w;
        f24_t z;
        f24_t y;
        f24_t x;
    } vec4_t;
endpackage

// File: rtl/fvl_f32_to_f24.sv
// Module: combinational single-precision to 24-bit float converter.
// Rebias 127 -> 63; exponent <= 64 flushes to signed zero, >= 191 saturates
// to signed infinity; mantissa truncated to its top 16 bits.
module fvl_f32_to_f24 #(
    parameter int IN_EXP_BIAS  = 127,
    parameter int OUT_EXP_BIAS = 63,
    parameter int OUT_EXP_W    = 7,
    parameter int OUT_MAN_W    = 16
) (
    input  logic [31:0]                     f32_in,
    output logic [OUT_EXP_W+OUT_MAN_W:0]    f24_out
);
    localparam int SHIFT   = IN_EXP_BIAS - OUT_EXP_BIAS;
    localparam int EXP_LO  = SHIFT + 1;
    localparam int EXP_HI  = SHIFT + (1 << OUT_EXP_W) - 2;
    localparam int DROP    = 23 - OUT_MAN_W;

    logic                 sgn;
    logic [7:0]           e_in;
    logic [8:0]           e_reb;

    // Split fields and select between zero, infinity and the normal result.
    always_comb begin
        sgn   = f32_in[31];
        e_in  = f32_in[30:23];
        e_reb = {1'b0, e_in} - 9'(SHIFT);
        if (int'(e_in) < EXP_LO) begin
            f24_out = {sgn, {(OUT_EXP_W+OUT_MAN_W){1'b0}}};
        end else if (int'(e_in) > EXP_HI) begin
            f24_out = {sgn, {OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
        end else begin
            f24_out = {sgn, e_reb[OUT_EXP_W-1:0], f32_in[22:DROP]};
        end
    end
endmodule

// File: rtl/fvl_word_collector.sv
// Module: holds the pending words of a partial vector and counts them.
// Assumes the format input is valid with each strobe; clr has priority.
module fvl_word_collector #(
    parameter int WORD_W = 32,
    parameter int NBUF   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [WORD_W-1:0] din,
    input  logic              fmt_f32,
    output logic              done,
    output logic [WORD_W-1:0] held [NBUF]
);
    localparam int CNT_W = $clog2(NBUF + 1);
    localparam logic [CNT_W-1:0] LAST_PK = CNT_W'(NBUF - 1);
    localparam logic [CNT_W-1:0] LAST_SP = CNT_W'(NBUF);

    logic [CNT_W-1:0] cnt;

    // Completion happens when the incoming word is the last one of its format.
    always_comb begin
        done = take && (fmt_f32 ? (cnt == LAST_SP) : (cnt >= LAST_PK));
    end

    // Advance or clear the word count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

    // Store each non-final word in the slot given by the count.
    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    held[g] <= '0;
                end else if (take && !done && cnt == CNT_W'(g)) begin
                    held[g] <= din;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fvl_vec_assemble.sv
// Module: builds the four-component vector from held words plus the final word.
// Packed: three words with straddling fields. Single: four converted words,
// first word into w.
module fvl_vec_assemble
    import fvl_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              fmt_f32,
    input  logic [WORD_W-1:0] held [3],
    input  logic [WORD_W-1:0] last,
    output vec4_t             vec
);
    logic [WORD_W-1:0] seq [NCOMP];
    f24_t              conv [NCOMP];
    vec4_t             pk;

    // Order the words as they arrived for single-precision mode.
    always_comb begin
        seq[0] = held[0];
        seq[1] = held[1];
        seq[2] = held[2];
        seq[3] = last;
    end

    generate
        for (genvar g = 0; g < NCOMP; g++) begin : g_cv
            fvl_f32_to_f24 u_cv (
                .f32_in  (seq[g]),
                .f24_out (conv[g])
            );
        end
    endgenerate

    // Unpack the three packed words; the third is the one arriving now.
    always_comb begin
        pk.w = held[0][31:8];
        pk.z = {held[0][7:0], held[1][31:16]};
        pk.y = {held[1][15:0], last[31:24]};
        pk.x = last[23:0];
    end

    // Choose the result for the active format.
    always_comb begin
        if (fmt_f32) begin
            vec.w = conv[0];
            vec.z = conv[1];
            vec.y = conv[2];
            vec.x = conv[3];
        end else begin
            vec = pk;
        end
    end
endmodule

// File: rtl/fvl_loader.sv
// Module: top of the float24 vector loader. Collects words, assembles a
// vector, writes it at the current index and advances the index.
// Assumes NUM_VEC <= 2**IDX_W; out-of-range indices raise range_err.
module fvl_loader
    import fvl_pkg::*;
#(
    parameter int NUM_VEC = 96,
    parameter int IDX_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [31:0]       word_data,
    input  logic              fmt_f32,
    input  logic              idx_set,
    input  logic [IDX_W-1:0]  idx_val,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [95:0]       mem_data,
    output logic              range_err
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_VEC);

    logic              take;
    logic              done;
    logic [31:0]       held [3];
    vec4_t             vec;
    logic [IDX_W-1:0]  idx;

    // A word is dropped when the index register is written in the same cycle.
    always_comb begin
        take = word_vld && !idx_set;
    end

    fvl_word_collector #(.WORD_W(WORD_W), .NBUF(3)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (idx_set),
        .take    (take),
        .din     (word_data),
        .fmt_f32 (fmt_f32),
        .done    (done),
        .held    (held)
    );

    fvl_vec_assemble #(.WORD_W(WORD_W)) u_asm (
        .fmt_f32 (fmt_f32),
        .held    (held),
        .last    (word_data),
        .vec     (vec)
    );

    // Index register update and registered write port / error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            range_err <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            range_err <= 1'b0;
            if (idx_set) begin
                idx <= idx_val;
            end else if (done) begin
                if ({1'b0, idx} < LIMIT) begin
                    mem_we   <= 1'b1;
                    mem_addr <= idx;
                    mem_data <= vec;
                    idx      <= idx + 1'b1;
                end else begin
                    range_err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fvl_loader_chk.sv
// Module: assertion checker for fvl_loader, attached by bind.
module fvl_loader_chk #(
    parameter int NUM_VEC = 96,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_vld,
    input logic             idx_set,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_addr,
    input logic             range_err
);
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                   // R7
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && range_err));                               // R9
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < NUM_VEC));                // R9
    AST_SET_DROPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_set |=> (!mem_we && !range_err));                  // R11
    AST_WE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(word_vld));                           // R7
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> !range_err);                             // R9
endmodule

bind fvl_loader fvl_loader_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .idx_set   (idx_set),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .range_err (range_err)
);

// File: tb/tb_fvl_loader.sv
module tb_fvl_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 5;

    // Table: format, four words, expected {w,z,y,x}.
    localparam logic        T_F32 [NT] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [31:0] T_W [NT][4] = '{
        '{32'h11223344, 32'h55667788, 32'h99AABBCC, 32'h0},
        '{32'h3F800000, 32'h40000000, 32'hBFC00000, 32'h20000000},
        '{32'hA0000000, 32'h7F000000, 32'hFF000000, 32'h20800000},
        '{32'h5F000000, 32'h3F812345, 32'h00000001, 32'h7F800000},
        '{32'hFFFFFFFF, 32'h00000000, 32'h80000001, 32'h0}};
    localparam logic [95:0] T_EXP [NT] = '{
        96'h112233_445566_778899_AABBCC,
        96'h3F0000_400000_BF8000_000000,
        96'h800000_7F0000_FF0000_010000,
        96'h7E0000_3F0246_000000_7F0000,
        96'hFFFFFF_FF0000_000080_000001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] word_data = '0;
    logic        fmt_f32 = 1'b0;
    logic        idx_set = 1'b0;
    logic [6:0]  idx_val = '0;
    logic        mem_we;
    logic [6:0]  mem_addr;
    logic [95:0] mem_data;
    logic        range_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fvl_loader dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
        .fmt_f32(fmt_f32), .idx_set(idx_set), .idx_val(idx_val),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .range_err(range_err));

    task automatic chk(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        word_vld = 1'b1; word_data = w;
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    task automatic set_idx(input logic [6:0] v);
        @(negedge clk);
        idx_set = 1'b1; idx_val = v;
        @(negedge clk);
        idx_set = 1'b0;
    endtask

    function automatic logic [95:0] unpk(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c);
        return {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
    endfunction

    task automatic push3(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        push(a); push(b); push(c);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_we == 1'b0, "R1 mem_we", 96'(mem_we), 96'd0);
        chk(range_err == 1'b0, "R1 range_err", 96'(range_err), 96'd0);
        rst_n = 1'b1;
        // R1: index starts at 0, so first vector goes to address 0
        for (int i = 0; i < NT; i++) begin
            fmt_f32 = T_F32[i];
            for (int k = 0; k < (T_F32[i] ? 4 : 3); k++) push(T_W[i][k]);
            chk(mem_we == 1'b1, T_F32[i] ? "R3 R7 we" : "R2 R7 we", 96'(mem_we), 96'd1);
            chk(mem_addr == 7'(i), "R1 R8 addr", 96'(mem_addr), 96'(i));
            chk(mem_data == T_EXP[i], T_F32[i] ? "R3 R4 R5 R6 data" : "R2 data",
                mem_data, T_EXP[i]);
            @(negedge clk);
            chk(mem_we == 1'b0, "R7 one-cycle", 96'(mem_we), 96'd0);
        end
        fmt_f32 = 1'b0;

        // R9: last valid slot, then out of range twice
        set_idx(7'd95);
        push3(32'h01020304, 32'h05060708, 32'h090A0B0C);
        chk(mem_we && mem_addr == 7'd95, "R9 last slot", 96'(mem_addr), 96'd95);
        push3(32'h1, 32'h2, 32'h3);
        chk(!mem_we && range_err, "R9 err pulse", {mem_we, range_err}, 96'b01);
        @(negedge clk);
        chk(!range_err, "R9 err one-cycle", 96'(range_err), 96'd0);
        push3(32'h1, 32'h2, 32'h3);
        chk(!mem_we && range_err, "R9 index held", {mem_we, range_err}, 96'b01);
        set_idx(7'd5);
        push3(32'hAABBCCDD, 32'hEEFF0011, 32'h22334455);
        chk(mem_we && mem_addr == 7'd5, "R10 reload", 96'(mem_addr), 96'd5);

        // R10: partial vector discarded by index write
        set_idx(7'd10);
        push(32'hDEADBEEF); push(32'hCAFEF00D);
        set_idx(7'd20);
        push(32'h12345678);
        chk(!mem_we, "R10 no early store", 96'(mem_we), 96'd0);
        push(32'h9ABCDEF0); push(32'h0F1E2D3C);
        chk(mem_we && mem_addr == 7'd20, "R10 addr", 96'(mem_addr), 96'd20);
        chk(mem_data == unpk(32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C), "R10 data",
            mem_data, unpk(32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C));

        // R11: word coincident with index write is ignored
        set_idx(7'd30);
        push(32'h55555555);
        @(negedge clk);
        word_vld = 1'b1; word_data = 32'h77777777; idx_set = 1'b1; idx_val = 7'd40;
        @(negedge clk);
        word_vld = 1'b0; idx_set = 1'b0;
        chk(!mem_we, "R11 no store", 96'(mem_we), 96'd0);
        push3(32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98);
        chk(mem_we && mem_addr == 7'd40, "R11 addr", 96'(mem_addr), 96'd40);
        chk(mem_data == unpk(32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98), "R11 data",
            mem_data, unpk(32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98));

        // R8: following vector at next address
        push3(32'h0, 32'h0, 32'h0);
        chk(mem_we && mem_addr == 7'd41, "R8 increment", 96'(mem_addr), 96'd41);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule